// File: doc/BRIEF.md
# Interrupt Cause and Mask Aggregator

This block gathers seven level-sensitive interrupt lines into a cause register, qualifies them with a per-line enable register and drives one combined request to a parent interrupt controller. Software reads and writes both registers over a simple single-cycle register bus.

The cause register is plain read/write, not write-zero-to-clear. Any bit written as 1 raises that interrupt, and any bit written as 0 clears it. A handler must therefore clear by read-modify-write. To keep a fresh hardware event from being lost in that window, a set coming from a line has priority over a simultaneous bus write of 0 to the same bit.

The block also publishes the number of the highest enabled pending line. A handler that walks from the top bit downward can use it without scanning.

Top module: `irq_agg_top`

## Requirements
- R1: While `rst` is high at a clock edge, both registers clear to 0. After that edge `irq_o`, `pend_valid_o`, `pend_idx_o` and `bus_rdata` are all 0.
- R2: A bus write to offset 0x50 loads the cause register with `bus_wdata[6:0]` exactly. A 1 bit sets a pending interrupt and a 0 bit clears it. The new value reads back at offset 0x50.
- R3: A bus write to offset 0x54 loads the enable register with `bus_wdata[6:0]`, where bit i = 1 enables line i. The register keeps its value in every cycle without such a write.
- R4: Register bits 31..7 always read as 0, whatever value was written to them.
- R5: A high level on `src_i[i]` at a clock edge sets cause bit i at that edge. If a bus write of 0 hits the same bit at the same edge, the bit still ends up 1.
- R6: `irq_o` is 1 exactly when some cause bit and its enable bit are both 1. It is registered one edge behind the register contents.
- R7: `pend_idx_o` holds the highest i for which cause bit i and enable bit i are both 1, and `pend_valid_o` is 1 in that case. With no such bit, `pend_valid_o` is 0 and `pend_idx_o` is 0.
- R8: A disabled line still latches into the cause register, but it does not raise `irq_o`.
- R9: A write to any offset other than 0x50 or 0x54 changes neither register. A read of such an offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 7 | Level interrupt lines |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 8 | Register byte offset, used for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for `bus_addr` |
| irq_o | output | 1 | Combined request to the parent controller |
| pend_valid_o | output | 1 | Some enabled line is pending |
| pend_idx_o | output | 3 | Highest enabled pending line number |

## Verification
A write or line event changes the registers at the edge where it is sampled. Read data for an offset is ready one edge after that offset is presented. The combined request and the pending index follow the registers one edge later, so they are due two edges after the write or event.

The bench drives inputs on the falling edge. After each stimulus it waits the exact number of rising edges listed above and samples at the next falling edge. The event-versus-write collision is driven in a single cycle, and its result is read back through the bus.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int          DEF_NUM_SRC   = 7;
  localparam int          DEF_ADDR_W    = 8;
  localparam int          DEF_DATA_W    = 32;
  localparam logic [7:0]  DEF_CAUSE_OFS = 8'h50;
  localparam logic [7:0]  DEF_MASK_OFS  = 8'h54;
endpackage

// File: rtl/irq_agg_regs.sv
module irq_agg_regs #(
  parameter int NUM_SRC = 7,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter logic [ADDR_W-1:0] CAUSE_OFS = 8'h50,
  parameter logic [ADDR_W-1:0] MASK_OFS  = 8'h54
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic [NUM_SRC-1:0] cause_o,
  output logic [NUM_SRC-1:0] mask_o
);
  logic [NUM_SRC-1:0] cause_q, mask_q, cause_base;
  logic [DATA_W-1:0]  rd_mux;
  logic               hit_cause, hit_mask;

  assign hit_cause = bus_wr && (bus_addr == CAUSE_OFS);
  assign hit_mask  = bus_wr && (bus_addr == MASK_OFS);

  // Bus value first, then line events OR'd on top: an event beats a written 0.
  assign cause_base = hit_cause ? bus_wdata[NUM_SRC-1:0] : cause_q;

  always_comb begin
    rd_mux = '0;
    if (bus_addr == CAUSE_OFS)     rd_mux[NUM_SRC-1:0] = cause_q;
    else if (bus_addr == MASK_OFS) rd_mux[NUM_SRC-1:0] = mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q   <= '0;
      mask_q    <= '0;
      bus_rdata <= '0;
    end else begin
      cause_q   <= cause_base | src_i;
      if (hit_mask) mask_q <= bus_wdata[NUM_SRC-1:0];
      bus_rdata <= rd_mux;
    end
  end

  assign cause_o = cause_q;
  assign mask_o  = mask_q;

  // R5: a line seen high at an edge is pending after that edge
  assert_event_sets_R5: assert property (@(posedge clk) disable iff (rst)
    (src_i != '0) |=> ((cause_q & $past(src_i)) == $past(src_i)));

  // R3: enable register holds without a write to its offset
  assert_mask_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !hit_mask |=> $stable(mask_q));

  // R4: unused read bits stay zero
  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DATA_W-1:NUM_SRC] == '0);

  // R9: writes elsewhere and quiet lines leave the cause register alone
  assert_cause_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!hit_cause && src_i == '0) |=> $stable(cause_q));
endmodule

// File: rtl/irq_agg_prio.sv
module irq_agg_prio #(
  parameter int NUM_SRC = 7,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] req_i,
  output logic               valid_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req_i[i]) idx_o = i[IDX_W-1:0];
    end
  end
  assign valid_o = |req_i;
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = DEF_NUM_SRC,
  parameter int ADDR_W  = DEF_ADDR_W,
  parameter int DATA_W  = DEF_DATA_W,
  parameter logic [ADDR_W-1:0] CAUSE_OFS = DEF_CAUSE_OFS,
  parameter logic [ADDR_W-1:0] MASK_OFS  = DEF_MASK_OFS,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_o,
  output logic               pend_valid_o,
  output logic [IDX_W-1:0]   pend_idx_o
);
  logic [NUM_SRC-1:0] cause, mask, live;
  logic               enc_valid;
  logic [IDX_W-1:0]   enc_idx;

  irq_agg_regs #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CAUSE_OFS(CAUSE_OFS), .MASK_OFS(MASK_OFS)
  ) regs_i (
    .clk(clk), .rst(rst), .src_i(src_i),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cause_o(cause), .mask_o(mask)
  );

  assign live = cause & mask;

  irq_agg_prio #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) prio_i (
    .req_i(live), .valid_o(enc_valid), .idx_o(enc_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o        <= 1'b0;
      pend_valid_o <= 1'b0;
      pend_idx_o   <= '0;
    end else begin
      irq_o        <= |live;
      pend_valid_o <= enc_valid;
      pend_idx_o   <= enc_idx;
    end
  end

  // R1: outputs quiet after a reset edge
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!irq_o && !pend_valid_o && pend_idx_o == '0));

  // R6/R7: OR path and encoder path agree
  assert_irq_valid_agree_R6: assert property (@(posedge clk) disable iff (rst)
    irq_o == pend_valid_o);

  // R7: index in range, and zero when nothing is pending
  assert_idx_range_R7: assert property (@(posedge clk) disable iff (rst)
    pend_valid_o ? (int'(pend_idx_o) < NUM_SRC) : (pend_idx_o == '0));
endmodule

// File: tb/irq_agg_top_tb.sv
module irq_agg_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] OFS_C = 8'h50;
  localparam logic [7:0] OFS_M = 8'h54;
  localparam int NV = 8;
  // {mask, cause, irq, valid, idx}
  localparam logic [18:0] VEC [NV] = '{
    {7'h7F, 7'h00, 1'b0, 1'b0, 3'd0},
    {7'h7F, 7'h01, 1'b1, 1'b1, 3'd0},
    {7'h7F, 7'h41, 1'b1, 1'b1, 3'd6},
    {7'h0F, 7'h70, 1'b0, 1'b0, 3'd0},
    {7'h0F, 7'h7C, 1'b1, 1'b1, 3'd3},
    {7'h00, 7'h7F, 1'b0, 1'b0, 3'd0},
    {7'h2A, 7'h2B, 1'b1, 1'b1, 3'd5},
    {7'h14, 7'h0C, 1'b1, 1'b1, 3'd2}
  };

  logic clk = 1'b0, rst = 1'b1, bus_wr = 1'b0;
  logic [6:0] src = '0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq, pvalid;
  logic [2:0] pidx;
  int nchk = 0, nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_agg_top dut_i (
    .clk(clk), .rst(rst), .src_i(src), .bus_wr(bus_wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq),
    .pend_valid_o(pvalid), .pend_idx_o(pidx)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 valid", {31'd0, pvalid}, 0);
    chk("R1 idx", {29'd0, pidx}, 0);
    chk("R1 rdata", rdata, 0);
    rd(OFS_C, r); chk("R1 cause", r, 0);
    rd(OFS_M, r); chk("R1 mask", r, 0);

    // Vector walk: R2, R3, R6, R7, R8
    for (int v = 0; v < NV; v++) begin
      wr(OFS_M, {25'd0, VEC[v][18:12]});
      wr(OFS_C, {25'd0, VEC[v][11:5]});
      settle();
      chk("R6 irq", {31'd0, irq}, {31'd0, VEC[v][4]});
      chk("R7 valid", {31'd0, pvalid}, {31'd0, VEC[v][3]});
      chk("R7 idx", {29'd0, pidx}, {29'd0, VEC[v][2:0]});
      rd(OFS_C, r); chk("R2 cause readback", r, {25'd0, VEC[v][11:5]});
      rd(OFS_M, r); chk("R3 mask readback", r, {25'd0, VEC[v][18:12]});
    end

    // R2 write 0 clears
    wr(OFS_C, 32'h0);
    settle();
    chk("R2 clear irq", {31'd0, irq}, 0);

    // R4 upper bits
    wr(OFS_C, 32'hFFFF_FF80 | 32'h05);
    rd(OFS_C, r); chk("R4 cause upper", r, 32'h05);
    wr(OFS_M, 32'hAAAA_AA80);
    rd(OFS_M, r); chk("R4 mask upper", r, 32'h0);

    // R9 other offset
    wr(OFS_M, 32'h11);
    wr(8'h58, 32'h7F);
    rd(OFS_C, r); chk("R9 cause kept", r, 32'h05);
    rd(OFS_M, r); chk("R9 mask kept", r, 32'h11);
    rd(8'h58, r); chk("R9 read other", r, 32'h0);

    // R5 event sets cause, R8 disabled line latches but no irq
    wr(OFS_C, 32'h0);
    wr(OFS_M, 32'h01);
    @(negedge clk); src = 7'h20;
    @(negedge clk); src = 7'h00;
    settle();
    chk("R8 disabled no irq", {31'd0, irq}, 0);
    rd(OFS_C, r); chk("R5 event latched", r, 32'h20);

    // R5 event beats a written zero in the same cycle
    wr(OFS_M, 32'h7F);
    @(negedge clk); addr = OFS_C; wdata = 32'h0; bus_wr = 1'b1; src = 7'h08;
    @(negedge clk); bus_wr = 1'b0; src = 7'h00;
    rd(OFS_C, r); chk("R5 event wins", r, 32'h08);
    chk("R7 idx after event", {29'd0, pidx}, 3);
    chk("R6 irq after event", {31'd0, irq}, 1);

    // R1 reset again clears everything
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 irq after reset", {31'd0, irq}, 0);
    rd(OFS_C, r); chk("R1 cause after reset", r, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule